// File: doc/BRIEF.md
# Triggered Transient Signal Averager

This block builds the average shape of a repetitive, noisy transient. Each trigger opens a sweep. The samples that follow are added into a row of bins in sequence, so bin k collects the k-th sample of every sweep. Repeating this over many sweeps averages out uncorrelated noise at each time point. The host divides by the sweep count afterwards to form the mean.

A host programs the number of sweeps and pulses start. The block then clears every bin and both counters, and arms itself for triggers. It reports done once the programmed number of sweeps has been accumulated. While the block is idle, the host reads the bin sums through an address/data port.

The default build takes 8-bit samples into 16 bins of 32 bits. A parameter set for 10-bit samples and 200 bins is also supported.

Top module: `trig_avg`

## Requirements
- R1: After reset, busy_o, done_o, sweep_cnt_o and missed_o are all 0. Bin contents are undefined until the first start.
- R2: A start pulse writes zero to every bin and zeroes sweep_cnt_o, missed_o and done_o. busy_o is high while the clear runs. A trigger during the clear is neither accepted nor counted.
- R3: In every sweep, the k-th accepted sample (k = 0 .. NUM_BINS-1) is added, unsigned, to bin k. A bin never wraps as long as BIN_W >= SAMPLE_W + SWEEP_W.
- R4: While a sweep is in progress, including the cycle in which its last write completes, a trigger has no effect on the sweep and increments missed_o by one.
- R5: A sample offered while armed and waiting for a trigger leaves every bin unchanged.
- R6: A sweep ends after its NUM_BINS-th sample has been written. sweep_cnt_o then increments by exactly one.
- R7: When sweep_cnt_o reaches the programmed count, done_o goes high and busy_o goes low. After that, triggers and samples change no bin and no counter.
- R8: A programmed count of zero finishes directly after the clear, with done_o high and every bin at zero.
- R9: While idle, rd_data_o shows the sum of bin rd_addr_i one cycle after the address is applied. In any cycle that follows a busy cycle, rd_data_o is 0.
- R10: A start pulse during a run abandons that run and begins a fresh measurement. It clears the bins and counters, and it loads the new sweep count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse: clear and begin a measurement |
| sweeps_i | input | SWEEP_W | Number of sweeps, captured at start |
| trig_i | input | 1 | Trigger that opens a sweep |
| sample_vld_i | input | 1 | A sample is offered on sample_i this cycle |
| sample_i | input | SAMPLE_W | Unsigned sample |
| rd_addr_i | input | IDX_W | Bin index to read |
| rd_data_o | output | BIN_W | Bin sum, one cycle after the address; 0 after a busy cycle |
| busy_o | output | 1 | A measurement is in progress |
| done_o | output | 1 | The programmed number of sweeps has been accumulated |
| sweep_cnt_o | output | SWEEP_W | Sweeps completed so far |
| missed_o | output | MISS_W | Triggers that arrived during a sweep |

## Verification
The assertions check on every cycle the following:
- done and busy are never high together;
- the sweep count only ever steps by one and never passes the target;
- done rises only at the target;
- the missed-trigger count moves only on a trigger during a sweep;
- no accumulation write is smaller than the value it replaces;
- the read port is gated while busy.

Only the bench's scenarios can show the rest:
- that sample k lands in bin k over many sweeps with gaps between samples;
- that stray samples and triggers during the clear leave no trace;
- that start truly zeroes old sums;
- that sums grow past 16 bits.

// File: rtl/avg_pkg.sv
package avg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_ARMED,
    ST_SWEEP,
    ST_DRAIN
  } avg_state_e;
endpackage

// File: rtl/avg_ctrl.sv
module avg_ctrl
  import avg_pkg::*;
#(
  parameter int NUM_BINS = 16,
  parameter int SWEEP_W  = 16,
  parameter int MISS_W   = 16,
  parameter int IDX_W    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [SWEEP_W-1:0] sweeps_i,
  input  logic               trig_i,
  input  logic               sample_vld_i,
  output avg_state_e         state_o,
  output logic [IDX_W-1:0]   bin_idx_o,
  output logic [IDX_W-1:0]   clr_idx_o,
  output logic               clr_o,
  output logic               take_o,
  output logic [SWEEP_W-1:0] tgt_o,
  output logic [SWEEP_W-1:0] sweep_cnt_o,
  output logic [MISS_W-1:0]  missed_o,
  output logic               done_o,
  output logic               busy_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BINS - 1);

  avg_state_e         state_q;
  logic [IDX_W-1:0]   bin_q, clr_q;
  logic [SWEEP_W-1:0] tgt_q, cnt_q;
  logic [MISS_W-1:0]  miss_q;
  logic               done_q;
  logic               in_sweep;

  assign in_sweep = (state_q == ST_SWEEP) || (state_q == ST_DRAIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bin_q   <= '0;
      clr_q   <= '0;
      tgt_q   <= '0;
      cnt_q   <= '0;
      miss_q  <= '0;
      done_q  <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_CLEAR;
      bin_q   <= '0;
      clr_q   <= '0;
      tgt_q   <= sweeps_i;
      cnt_q   <= '0;
      miss_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      if (in_sweep && trig_i) miss_q <= miss_q + 1'b1;
      unique case (state_q)
        ST_CLEAR: begin
          clr_q <= clr_q + 1'b1;
          if (clr_q == LAST_IDX) begin
            if (tgt_q == '0) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_ARMED;
            end
          end
        end
        ST_ARMED: begin
          if (trig_i) begin
            state_q <= ST_SWEEP;
            bin_q   <= '0;
          end
        end
        ST_SWEEP: begin
          if (sample_vld_i) begin
            bin_q <= bin_q + 1'b1;
            if (bin_q == LAST_IDX) state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          // last write lands this cycle
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q + 1'b1 == tgt_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_ARMED;
          end
        end
        default: ;
      endcase
    end
  end

  assign state_o     = state_q;
  assign bin_idx_o   = bin_q;
  assign clr_idx_o   = clr_q;
  assign clr_o       = (state_q == ST_CLEAR);
  assign take_o      = (state_q == ST_SWEEP) && sample_vld_i;
  assign tgt_o       = tgt_q;
  assign sweep_cnt_o = cnt_q;
  assign missed_o    = miss_q;
  assign done_o      = done_q;
  assign busy_o      = (state_q != ST_IDLE);
endmodule

// File: rtl/avg_rmw.sv
module avg_rmw #(
  parameter int SAMPLE_W = 8,
  parameter int BIN_W    = 32,
  parameter int IDX_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                take_i,
  input  logic [IDX_W-1:0]    bin_idx_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                clr_i,
  input  logic [IDX_W-1:0]    clr_idx_i,
  input  logic [BIN_W-1:0]    old_i,
  output logic                we_o,
  output logic [IDX_W-1:0]    waddr_o,
  output logic [BIN_W-1:0]    wdata_o,
  output logic                acc_wr_o
);
  logic                p_vld_q;
  logic [IDX_W-1:0]    p_idx_q;
  logic [SAMPLE_W-1:0] p_smp_q;
  logic [BIN_W-1:0]    smp_ext;

  generate
    if (BIN_W > SAMPLE_W) begin : g_ext
      assign smp_ext = {{(BIN_W-SAMPLE_W){1'b0}}, p_smp_q};
    end else begin : g_trunc
      assign smp_ext = p_smp_q[BIN_W-1:0];
    end
  endgenerate

  // stage 0: read issued with the sample; stage 1: add and write back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_vld_q <= 1'b0;
      p_idx_q <= '0;
      p_smp_q <= '0;
    end else begin
      p_vld_q <= take_i;
      if (take_i) begin
        p_idx_q <= bin_idx_i;
        p_smp_q <= sample_i;
      end
    end
  end

  always_comb begin
    we_o    = 1'b0;
    waddr_o = p_idx_q;
    wdata_o = old_i + smp_ext;
    if (clr_i) begin
      we_o    = 1'b1;
      waddr_o = clr_idx_i;
      wdata_o = '0;
    end else if (p_vld_q) begin
      we_o = 1'b1;
    end
  end

  assign acc_wr_o = p_vld_q && !clr_i;
endmodule

// File: rtl/avg_bin_mem.sv
module avg_bin_mem #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  parameter int AW    = 4
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/trig_avg.sv
module trig_avg
  import avg_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int NUM_BINS = 16,
  parameter int BIN_W    = 32,
  parameter int SWEEP_W  = 16,
  parameter int MISS_W   = 16,
  localparam int IDX_W   = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SWEEP_W-1:0]  sweeps_i,
  input  logic                trig_i,
  input  logic                sample_vld_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [IDX_W-1:0]    rd_addr_i,
  output logic [BIN_W-1:0]    rd_data_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [SWEEP_W-1:0]  sweep_cnt_o,
  output logic [MISS_W-1:0]   missed_o
);
  avg_state_e         state;
  logic [IDX_W-1:0]   bin_idx, clr_idx, mem_waddr, mem_raddr;
  logic               clr, take, mem_we, acc_wr, rd_host_q;
  logic [SWEEP_W-1:0] tgt_q;
  logic [BIN_W-1:0]   mem_wdata, mem_rdata;

  avg_ctrl #(
    .NUM_BINS(NUM_BINS), .SWEEP_W(SWEEP_W), .MISS_W(MISS_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .sweeps_i(sweeps_i),
    .trig_i(trig_i), .sample_vld_i(sample_vld_i), .state_o(state),
    .bin_idx_o(bin_idx), .clr_idx_o(clr_idx), .clr_o(clr), .take_o(take),
    .tgt_o(tgt_q), .sweep_cnt_o(sweep_cnt_o), .missed_o(missed_o),
    .done_o(done_o), .busy_o(busy_o)
  );

  avg_rmw #(
    .SAMPLE_W(SAMPLE_W), .BIN_W(BIN_W), .IDX_W(IDX_W)
  ) u_rmw (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take), .bin_idx_i(bin_idx),
    .sample_i(sample_i), .clr_i(clr), .clr_idx_i(clr_idx), .old_i(mem_rdata),
    .we_o(mem_we), .waddr_o(mem_waddr), .wdata_o(mem_wdata), .acc_wr_o(acc_wr)
  );

  // one read port, owned by the accumulator while busy
  assign mem_raddr = busy_o ? bin_idx : rd_addr_i;

  avg_bin_mem #(
    .DEPTH(NUM_BINS), .WIDTH(BIN_W), .AW(IDX_W)
  ) u_mem (
    .clk_i(clk_i), .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .raddr_i(mem_raddr), .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_host_q <= 1'b0;
    else         rd_host_q <= !busy_o;
  end

  assign rd_data_o = rd_host_q ? mem_rdata : '0;
endmodule

// File: rtl/avg_chk.sv
module avg_chk #(
  parameter int BIN_W   = 32,
  parameter int SWEEP_W = 16,
  parameter int MISS_W  = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               trig_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [SWEEP_W-1:0] sweep_cnt_o,
  input logic [MISS_W-1:0]  missed_o,
  input logic [BIN_W-1:0]   rd_data_o,
  input logic [SWEEP_W-1:0] tgt_q,
  input logic               acc_wr,
  input logic [BIN_W-1:0]   mem_wdata,
  input logic [BIN_W-1:0]   mem_rdata
);
  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_count_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweep_cnt_o <= tgt_q);

  assert_done_at_target_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> sweep_cnt_o == tgt_q);

  assert_sweep_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sweep_cnt_o) && !$past(start_i))
      |-> sweep_cnt_o == SWEEP_W'($past(sweep_cnt_o) + 1'b1));

  assert_missed_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(missed_o) && !$past(start_i)) |-> ($past(trig_i) && $past(busy_o)));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_wr |-> mem_wdata >= mem_rdata);

  assert_read_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> rd_data_o == '0);
endmodule

bind trig_avg avg_chk #(
  .BIN_W(BIN_W), .SWEEP_W(SWEEP_W), .MISS_W(MISS_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .trig_i(trig_i),
  .busy_o(busy_o), .done_o(done_o), .sweep_cnt_o(sweep_cnt_o),
  .missed_o(missed_o), .rd_data_o(rd_data_o), .tgt_q(tgt_q),
  .acc_wr(acc_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
);

// File: tb/trig_avg_test.sv
module trig_avg_test;
  localparam int NB = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] sweeps = '0;
  logic        trig = 1'b0;
  logic        vld = 1'b0;
  logic [7:0]  smp = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        busy, done;
  logic [15:0] scnt, missed;

  int n_chk = 0;
  int n_bad = 0;
  longint exp_bin [NB];
  int exp_miss = 0;

  trig_avg uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sweeps_i(sweeps),
    .trig_i(trig), .sample_vld_i(vld), .sample_i(smp), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .busy_o(busy), .done_o(done),
    .sweep_cnt_o(scnt), .missed_o(missed)
  );

  always #5 clk = ~clk;

  // {base, step, flags}: flag0 gap between samples, flag1 trigger mid-sweep,
  // flag2 stray samples before the trigger
  localparam logic [18:0] VEC [5] = '{
    {8'd10,  8'd3,  3'b000},
    {8'd200, 8'd7,  3'b001},
    {8'd0,   8'd17, 3'b010},
    {8'd255, 8'd1,  3'b100},
    {8'd90,  8'd0,  3'b011}
  };

  task automatic tick(); @(negedge clk); endtask

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [15:0] n, input bit trig_in_clear);
    sweeps = n; start = 1'b1; tick(); start = 1'b0;
    for (int i = 0; i < NB + 4; i++) begin
      if (trig_in_clear && i == 2) trig = 1'b1;
      tick();
      trig = 1'b0;
    end
    for (int i = 0; i < NB; i++) exp_bin[i] = 0;
    exp_miss = 0;
  endtask

  task automatic do_sweep(input logic [7:0] base, input logic [7:0] step, input logic [2:0] fl);
    if (fl[2]) begin
      for (int i = 0; i < 3; i++) begin smp = 8'd200; vld = 1'b1; tick(); end
      vld = 1'b0;
    end
    trig = 1'b1; tick(); trig = 1'b0;
    for (int k = 0; k < NB; k++) begin
      smp = 8'(base + step * k);
      vld = 1'b1;
      if (fl[1] && k == 5) begin trig = 1'b1; exp_miss++; end
      exp_bin[k] += smp;
      tick();
      vld = 1'b0; trig = 1'b0;
      if (fl[0]) tick();
    end
    repeat (3) tick();
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < NB; i++) begin
      rd_addr = 4'(i); tick();
      check(req, rd_data, exp_bin[i]);
    end
  endtask

  initial begin
    #1ms;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 sweeps", scnt, 0);
    check("R1 missed", missed, 0);
    rst_n = 1'b1; tick();

    // fill bins with old data
    do_start(16'd2, 1'b0);
    do_sweep(8'd7, 8'd0, 3'b000);
    do_sweep(8'd7, 8'd0, 3'b000);
    check("R7 done", done, 1);
    read_all("R3 prefill");

    // R2: start clears old sums; trigger during clear ignored
    do_start(16'd5, 1'b1);
    check("R2 missed after clear-trigger", missed, 0);
    check("R2 count", scnt, 0);
    check("R2 busy", busy, 1);
    for (int v = 0; v < 5; v++) begin
      do_sweep(VEC[v][18:11], VEC[v][10:3], VEC[v][2:0]);
      check("R6 sweep count", scnt, v + 1);
      if (v == 0) begin
        rd_addr = 4'd0; tick(); tick();
        check("R9 read while busy", rd_data, 0);
      end
      if (v < 4) check("R7 not done yet", done, 0);
    end
    check("R7 done", done, 1);
    check("R7 idle", busy, 0);
    check("R4 missed", missed, exp_miss);
    read_all("R3 R5 table sums");

    // R7: activity after done has no effect
    do_sweep(8'd50, 8'd1, 3'b010);
    for (int i = 0; i < NB; i++) exp_bin[i] -= 8'(50 + i);
    exp_miss--;
    check("R7 count frozen", scnt, 5);
    check("R7 missed frozen", missed, exp_miss);
    read_all("R7 bins frozen");

    // R8: zero sweeps
    do_start(16'd0, 1'b0);
    check("R8 done", done, 1);
    check("R8 idle", busy, 0);
    read_all("R8 bins zero");

    // R10: restart mid-run
    do_start(16'd3, 1'b0);
    do_sweep(8'd1, 8'd0, 3'b000);
    check("R10 first run count", scnt, 1);
    do_start(16'd1, 1'b0);
    check("R10 count reset", scnt, 0);
    do_sweep(8'd2, 8'd1, 3'b000);
    check("R10 done", done, 1);
    read_all("R10 fresh sums");

    // R3: sums past 16 bits
    do_start(16'd300, 1'b0);
    for (int s = 0; s < 300; s++) do_sweep(8'd255, 8'd0, 3'b000);
    check("R3 big done", done, 1);
    check("R3 big count", scnt, 300);
    read_all("R3 wide sums");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule